// File: doc/BRIEF.md
# Backplane Bus Mastership Requester

This block sits on one board of a shared backplane and wins bus ownership on behalf of local logic. Ownership is handled with two open-collector style lines, both active low. One is a request line that any board may pull down. The other is a busy line that the owner holds down. When local logic asks for the bus, the block pulls the request line low. It waits until the current owner lets the busy line go high. It then takes the bus by pulling the busy line low and releasing its request on the same clock edge.

Taking the bus is separate from granting it to local logic. The previous owner may still be finishing its last data cycle, with the address strobe held low. The local grant therefore rises only once the strobe is seen high. While it owns the bus, the block gives it up when another board requests it. Whether it releases during or after the final transfer depends on when that request was seen, measured against the start of the current strobe.

All three backplane inputs are passed through a synchroniser of `SYNC_STAGES` flops before any decision uses them. Every output comes from a flop.

Top module: `bus_mastership_requester`

## Requirements
- R1: During and after synchronous reset, bus_req_n_o and bus_busy_n_o are 1 and local_grant_o is 0.
- R2: One clock edge after local_req_i is seen high by an idle requester, bus_req_n_o goes to 0. It stays 0 until the edge on which bus_busy_n_o goes to 0, and it is never 0 while bus_busy_n_o is 0.
- R3: bus_busy_n_o goes to 0 only after the synchronised busy line has been sampled high on MIN_GAP+1 consecutive edges (two with the default). bus_req_n_o returns to 1 on that same edge. A high pulse on the busy line that is shorter than this does not cause a take.
- R4: local_grant_o is 1 only while bus_busy_n_o is 0. It rises no earlier than one edge after the take, and only on an edge at which the synchronised strobe is high (negated).
- R5: The owner releases during its last transfer when three conditions hold: another board's request was already seen while the strobe was high, local_last_i is 1, and the strobe has since gone low. bus_busy_n_o then rises one edge after local_last_i rises, even though addr_strobe_n_i is still 0.
- R6: If another board's request first appears while the owner's strobe is low, the owner holds the bus until the strobe is seen high again. The release then follows SYNC_STAGES+1 edges after addr_strobe_n_i rises.
- R7: While local_req_i is 1 and local_last_i is 0, the owner keeps the bus even when another board is requesting.
- R8: With no other board requesting, the owner keeps the bus and the grant even after local_req_i falls (bus parking).
- R9: A change on a backplane input affects outputs no earlier than SYNC_STAGES+1 edges later. With defaults, a busy-line rise seen by a waiting requester gives bus_busy_n_o = 0 four edges later, and a strobe rise during a pending grant gives local_grant_o = 1 three edges later.
- R10: On release, bus_busy_n_o rises and local_grant_o falls on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| local_req_i | input | 1 | Local logic wants the bus |
| local_last_i | input | 1 | The current or next local transfer is the final one |
| bus_req_n_i | input | 1 | Backplane request line as seen from the other boards, low = someone requests |
| bus_busy_n_i | input | 1 | Backplane busy line, high = no owner |
| addr_strobe_n_i | input | 1 | Backplane address strobe, low = a data cycle is in flight |
| bus_req_n_o | output | 1 | Drive of the request line, low = requesting |
| bus_busy_n_o | output | 1 | Drive of the busy line, low = this board owns the bus |
| local_grant_o | output | 1 | Local logic may start data cycles |

## Verification
Wrong internal state shows first on the three output pins, within a few edges. A stale gap counter appears as bus_busy_n_o falling one or more edges early or late after the busy line rises. A wrong early-release flag makes bus_busy_n_o rise while the strobe is still low when it should wait, or the reverse. A lost owner state drops local_grant_o without a matching rise of bus_busy_n_o. The bench compares all three outputs on every clock with a behavioural model, so each of these appears on the first cycle in which it differs.

// File: rtl/bmr_pkg.sv
package bmr_pkg;
  typedef enum logic [1:0] {
    RQ_IDLE = 2'd0,
    RQ_WAIT = 2'd1,
    RQ_HOLD = 2'd2,
    RQ_OWN  = 2'd3
  } rq_state_t;
endpackage

// File: rtl/bmr_sync.sv
module bmr_sync #(
  parameter int WIDTH     = 3,
  parameter int STAGES    = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] chain [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= RESET_VAL;
          else     chain[g] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= RESET_VAL;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/bmr_take_timer.sv
module bmr_take_timer #(
  parameter int MIN_GAP = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic arm_i,
  input  logic free_i,
  output logic take_o
);
  localparam int CW = $clog2(MIN_GAP + 1) + 1;
  localparam logic [CW-1:0] LIMIT = CW'(MIN_GAP);

  logic [CW-1:0] cnt;

  assign take_o = arm_i && free_i && (cnt >= LIMIT);

  always_ff @(posedge clk) begin
    if (rst || !arm_i || !free_i) cnt <= '0;
    else if (cnt < LIMIT)         cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/bmr_release_policy.sv
module bmr_release_policy (
  input  logic clk,
  input  logic rst,
  input  logic owner_i,
  input  logic other_req_i,
  input  logic strobe_idle_i,
  input  logic local_req_i,
  input  logic local_last_i,
  output logic release_o
);
  logic seen_before_strobe;

  always_ff @(posedge clk) begin
    if (rst || !owner_i)    seen_before_strobe <= 1'b0;
    else if (strobe_idle_i) seen_before_strobe <= other_req_i;
  end

  assign release_o = owner_i && other_req_i
                  && (local_last_i || !local_req_i)
                  && (strobe_idle_i || seen_before_strobe);
endmodule

// File: rtl/bus_mastership_requester.sv
module bus_mastership_requester
  import bmr_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_GAP     = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic local_req_i,
  input  logic local_last_i,
  input  logic bus_req_n_i,
  input  logic bus_busy_n_i,
  input  logic addr_strobe_n_i,
  output logic bus_req_n_o,
  output logic bus_busy_n_o,
  output logic local_grant_o
);
  localparam int NSIG = 3;

  logic [NSIG-1:0] raw_lines, sync_lines;
  logic other_req, bus_free, strobe_idle;
  logic take, rel;
  rq_state_t state, state_nx;

  assign raw_lines = {addr_strobe_n_i, bus_busy_n_i, bus_req_n_i};

  bmr_sync #(.WIDTH(NSIG), .STAGES(SYNC_STAGES), .RESET_VAL('1)) u_sync (
    .clk(clk), .rst(rst), .d_i(raw_lines), .q_o(sync_lines)
  );

  assign other_req   = !sync_lines[0];
  assign bus_free    =  sync_lines[1];
  assign strobe_idle =  sync_lines[2];

  bmr_take_timer #(.MIN_GAP(MIN_GAP)) u_timer (
    .clk(clk), .rst(rst), .arm_i(state == RQ_WAIT), .free_i(bus_free),
    .take_o(take)
  );

  bmr_release_policy u_policy (
    .clk(clk), .rst(rst), .owner_i(state == RQ_OWN), .other_req_i(other_req),
    .strobe_idle_i(strobe_idle), .local_req_i(local_req_i),
    .local_last_i(local_last_i), .release_o(rel)
  );

  always_comb begin
    state_nx = state;
    unique case (state)
      RQ_IDLE: if (local_req_i) state_nx = RQ_WAIT;
      RQ_WAIT: if (take)        state_nx = RQ_HOLD;
      RQ_HOLD: if (strobe_idle) state_nx = RQ_OWN;
      RQ_OWN:  if (rel)         state_nx = RQ_IDLE;
      default:                  state_nx = RQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= RQ_IDLE;
      bus_req_n_o   <= 1'b1;
      bus_busy_n_o  <= 1'b1;
      local_grant_o <= 1'b0;
    end else begin
      state         <= state_nx;
      bus_req_n_o   <= (state_nx != RQ_WAIT);
      bus_busy_n_o  <= !((state_nx == RQ_HOLD) || (state_nx == RQ_OWN));
      local_grant_o <= (state_nx == RQ_OWN);
    end
  end
endmodule

// File: rtl/bmr_checker.sv
module bmr_checker (
  input logic clk,
  input logic rst,
  input logic local_req_i,
  input logic bus_req_n_o,
  input logic bus_busy_n_o,
  input logic local_grant_o
);
  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (bus_req_n_o && bus_busy_n_o && !local_grant_o));

  assert_no_req_while_owner_R2: assert property (@(posedge clk) disable iff (rst)
    !bus_req_n_o |-> bus_busy_n_o);

  assert_take_drops_req_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_busy_n_o) |-> ($rose(bus_req_n_o) && $past(!bus_req_n_o)));

  assert_grant_needs_bus_R4: assert property (@(posedge clk) disable iff (rst)
    local_grant_o |-> !bus_busy_n_o);

  assert_grant_after_take_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(local_grant_o) |-> $past(!bus_busy_n_o));

  assert_release_together_R10: assert property (@(posedge clk) disable iff (rst)
    $fell(local_grant_o) |-> $rose(bus_busy_n_o));

  assert_request_follows_local_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_req_n_o) |-> $past(local_req_i));
endmodule

bind bus_mastership_requester bmr_checker u_bmr_checker (
  .clk(clk), .rst(rst), .local_req_i(local_req_i), .bus_req_n_o(bus_req_n_o),
  .bus_busy_n_o(bus_busy_n_o), .local_grant_o(local_grant_o)
);

// File: tb/tb_bus_mastership_requester.sv
module tb_bus_mastership_requester;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lreq = 1'b0, llast = 1'b0, ebreq_n = 1'b1, ebusy_n = 1'b1, estb_n = 1'b1;
  logic breq_n_o, busy_n_o, grant_o;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  bus_mastership_requester dut (
    .clk(clk), .rst(rst), .local_req_i(lreq), .local_last_i(llast),
    .bus_req_n_i(ebreq_n), .bus_busy_n_i(ebusy_n), .addr_strobe_n_i(estb_n),
    .bus_req_n_o(breq_n_o), .bus_busy_n_o(busy_n_o), .local_grant_o(grant_o)
  );

  // behavioural reference model: 0 idle, 1 requesting, 2 owns/waiting strobe, 3 granted
  int st = 0, gapc = 0, early = 0;
  bit pb[2], ps[2], pr[2];
  bit x_breq = 1, x_busy = 1, x_grant = 0;

  always @(posedge clk) begin
    if (rst) begin
      pb = '{1, 1}; ps = '{1, 1}; pr = '{1, 1};
      st = 0; gapc = 0; early = 0;
      x_breq = 1; x_busy = 1; x_grant = 0;
    end else begin
      bit free, sidle, oreq;
      int nst, ngap, nearly;
      free = pb[1]; sidle = ps[1]; oreq = !pr[1];
      nst = st; ngap = gapc; nearly = early;
      if (st == 0) begin
        if (lreq) nst = 1;
      end else if (st == 1) begin
        if (!free) ngap = 0;
        else if (gapc >= 1) nst = 2;
        else ngap = gapc + 1;
      end else if (st == 2) begin
        if (sidle) nst = 3;
      end else begin
        if (oreq && (llast || !lreq) && (sidle || early != 0)) nst = 0;
      end
      if (st != 1) ngap = 0;
      if (st != 3) nearly = 0;
      else if (sidle) nearly = oreq;
      pb[1] = pb[0]; pb[0] = ebusy_n;
      ps[1] = ps[0]; ps[0] = estb_n;
      pr[1] = pr[0]; pr[0] = ebreq_n;
      st = nst; gapc = ngap; early = nearly;
      x_breq = (st != 1);
      x_busy = !(st == 2 || st == 3);
      x_grant = (st == 3);
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R2 model bus_req_n_o", breq_n_o, x_breq);
      chk("R3 model bus_busy_n_o", busy_n_o, x_busy);
      chk("R4 model local_grant_o", grant_o, x_grant);
    end
  end

  task automatic adv(int k);
    repeat (k) @(posedge clk);
    #2;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    ebusy_n = 1'b0;
    adv(3);
    chk("R1 reset req", breq_n_o, 1);
    chk("R1 reset busy", busy_n_o, 1);
    chk("R1 reset grant", grant_o, 0);
    rst = 1'b0;
    adv(3);
    chk("R1 after reset busy", busy_n_o, 1);
    // request while another board owns the bus
    lreq = 1'b1;
    adv(1);
    chk("R2 request asserted", breq_n_o, 0);
    adv(10);
    chk("R2 request held", breq_n_o, 0);
    chk("R2 not owner yet", busy_n_o, 1);
    // owner releases busy while its strobe is still low
    ebusy_n = 1'b1; estb_n = 1'b0;
    adv(3);
    chk("R9 busy not yet taken", busy_n_o, 1);
    adv(1);
    chk("R3 busy taken", busy_n_o, 0);
    chk("R3 request dropped with take", breq_n_o, 1);
    adv(5);
    chk("R4 no grant while strobe low", grant_o, 0);
    estb_n = 1'b1;
    adv(2);
    chk("R9 grant not yet", grant_o, 0);
    adv(1);
    chk("R4 grant after strobe negated", grant_o, 1);
    // parking
    lreq = 1'b0;
    adv(10);
    chk("R8 parked busy", busy_n_o, 0);
    chk("R8 parked grant", grant_o, 1);
    // more transfers pending: keep bus
    lreq = 1'b1; llast = 1'b0; ebreq_n = 1'b0;
    adv(10);
    chk("R7 kept with pending transfers", grant_o, 1);
    // own strobe goes low after the request was seen
    estb_n = 1'b0;
    adv(5);
    chk("R7 still kept", busy_n_o, 0);
    llast = 1'b1; ebusy_n = 1'b0;
    adv(1);
    chk("R5 released during transfer", busy_n_o, 1);
    chk("R10 grant dropped with release", grant_o, 0);
    chk("R5 strobe still low", estb_n, 0);
    adv(1);
    chk("R2 re-request", breq_n_o, 0);
    // regain the bus
    estb_n = 1'b1; ebreq_n = 1'b1; ebusy_n = 1'b1;
    adv(8);
    chk("R4 regained grant", grant_o, 1);
    estb_n = 1'b0;
    adv(3);
    ebreq_n = 1'b0;
    adv(8);
    chk("R6 held while strobe low", busy_n_o, 0);
    estb_n = 1'b1; ebusy_n = 1'b0;
    adv(2);
    chk("R6 not yet released", busy_n_o, 0);
    adv(1);
    chk("R6 released after strobe", busy_n_o, 1);
    chk("R10 grant low on release", grant_o, 0);
    adv(4);
    // short busy pulse must not cause a take
    ebusy_n = 1'b1;
    adv(1);
    ebusy_n = 1'b0;
    adv(6);
    chk("R3 short pulse ignored busy", busy_n_o, 1);
    chk("R3 short pulse still requesting", breq_n_o, 0);
    ebusy_n = 1'b1;
    adv(3);
    chk("R3 gap not elapsed", busy_n_o, 1);
    adv(1);
    chk("R3 take after gap", busy_n_o, 0);
    adv(4);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule